// File: doc/BRIEF.md
# Capture Timer/Event Counter

This block is a 16-bit up-counter for a small microcontroller. It can count in two ways. In timer mode it advances once per machine cycle. In event mode it counts falling edges on an external pin. It runs from the oscillator clock. An internal phase counter divides each machine cycle into twelve clock periods. The external pins are sampled once per machine cycle, at a fixed phase, and a falling edge needs a high sample followed by a low sample.

When the count wraps from FFFFh to 0000h, the block raises an overflow flag. When capture is enabled, a falling edge on a second external pin copies the current count into a capture register and raises a trigger flag. Software can load either byte of the count and clear each flag with a pulse. The block offers a single interrupt request line, which is the OR of the two flags.

Top module: `cap_timer16`

## Requirements
- R1: While `rst` is high at a clock edge, the count and the capture register load 0000h and both flags load 0. The internal phase counter loads 0, and both pin sample registers load 0.
- R2: After reset, the phase counter advances by one on every clock edge and wraps from 11 to 0. In timer mode (`count_sel` = 0) with `run_en` high, the count increments exactly once per machine cycle, at the edge where the phase is 2.
- R3: In event mode (`count_sel` = 1), `cnt_pin` is sampled at the edge where the phase is 9. A falling edge is recognised when the previously stored sample is 1 and the new sample is 0.
- R4: A falling edge on `cnt_pin` recognised at a phase-9 edge increments the count at the next phase-2 edge. That is five clocks later, and the count does not change before then. A pending edge is discarded at that phase-2 edge whether or not it was used.
- R5: An increment applied while the count is FFFFh wraps the count to 0000h and sets `ovf_flag`.
- R6: Each flag stays set until its clear input is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R7: With `ext_en` = 1, `trig_pin` is sampled in the same way as `cnt_pin` (phase 9, a 1 followed by a 0). A recognised falling edge does two things at the next phase-2 edge: it copies the count, as it was before that edge, into `cap_hi`/`cap_lo`, and it sets `trig_flag`.
- R8: With `ext_en` = 0, edges on `trig_pin` leave the capture register and `trig_flag` unchanged.
- R9: With `run_en` = 0, the count holds its value, except for software writes. Capture on `trig_pin` still works when `ext_en` = 1.
- R10: `wr_hi` loads `wr_data` into the high byte of the count, and `wr_lo` loads it into the low byte. Either write takes priority over an increment on the same edge, and that edge then does not set `ovf_flag`.
- R11: `irq` is high exactly when `ovf_flag` or `trig_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Count enable |
| count_sel | input | 1 | 0 = timer mode, 1 = event mode on cnt_pin |
| ext_en | input | 1 | Enables capture on trig_pin |
| cnt_pin | input | 1 | External event input |
| trig_pin | input | 1 | External capture trigger |
| wr_hi | input | 1 | Load wr_data into the count high byte |
| wr_lo | input | 1 | Load wr_data into the count low byte |
| wr_data | input | 8 | Software write data |
| ovf_clr | input | 1 | Clear pulse for ovf_flag |
| trig_clr | input | 1 | Clear pulse for trig_flag |
| cnt_hi | output | 8 | Count, high byte |
| cnt_lo | output | 8 | Count, low byte |
| cap_hi | output | 8 | Captured count, high byte |
| cap_lo | output | 8 | Captured count, low byte |
| ovf_flag | output | 1 | Overflow flag |
| trig_flag | output | 1 | Capture trigger flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the local rules that link one edge to the next. They cover the phase range, that the sample and update strobes never coincide, a single step for every unblocked increment, the hold when the block is stopped, wraparound setting the overflow flag, a capture taking the pre-edge count, and a frozen capture register while capture is disabled. The bench's scenarios are needed for the behaviour that spans cycles. That includes the five-clock delay from a recognised edge to the increment, the loss of pulses shorter than a machine cycle, the priority of a write landing on an update edge, flag persistence and clearing, and the exact count after a train of pin pulses.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } count_mode_e;

  // A falling edge needs a stored high sample and a new low sample.
  function automatic logic is_fall(input logic prev_smp, input logic new_smp);
    return prev_smp & ~new_smp;
  endfunction

  // Flag update: a hardware set beats a software clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/ct_phase_gen.sv
module ct_phase_gen #(
  parameter int MC_LEN = 12,
  parameter int SMP_PH = 9,
  parameter int UPD_PH = 2,
  localparam int PH_W = $clog2(MC_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            smp_stb,
  output logic            upd_stb
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_LEN - 1);
  localparam logic [PH_W-1:0] SMP_V   = PH_W'(SMP_PH);
  localparam logic [PH_W-1:0] UPD_V   = PH_W'(UPD_PH);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                    phase_q <= '0;
    else if (phase_q == LAST_PH) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign phase   = phase_q;
  assign smp_stb = (phase_q == SMP_V);
  assign upd_stb = (phase_q == UPD_V);

endmodule

// File: rtl/ct_fall_sampler.sv
module ct_fall_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_stb,
  input  logic         upd_stb,
  input  logic [N-1:0] pin,
  output logic [N-1:0] pend
);
  import cap_timer_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic smp_q;
    logic pend_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (smp_stb) begin
        smp_q  <= pin[g];
        pend_q <= is_fall(smp_q, pin[g]);
      end else if (upd_stb) begin
        pend_q <= 1'b0;
      end
    end

    assign pend[g] = pend_q;
  end

endmodule

// File: rtl/ct_count_core.sv
module ct_count_core #(
  parameter int W = 16,
  localparam int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_stb,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [HW-1:0] wr_data,
  output logic [W-1:0]  count,
  output logic          roll_evt
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  function automatic logic [W-1:0] step_count(input logic [W-1:0] c, input logic en);
    return en ? c + W'(1) : c;
  endfunction

  function automatic logic [W-1:0] apply_write(input logic [W-1:0] c,
                                               input logic hi, input logic lo,
                                               input logic [HW-1:0] d);
    logic [W-1:0] r;
    r = c;
    if (hi) r[W-1:HW] = d;
    if (lo) r[HW-1:0] = d;
    return r;
  endfunction

  // Writes override the increment, so a write edge never wraps.
  assign count_d  = apply_write(step_count(count_q, inc_stb), wr_hi, wr_lo, wr_data);
  assign roll_evt = inc_stb & ~(wr_hi | wr_lo) & (&count_q);

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/ct_event_regs.sv
module ct_event_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_evt,
  input  logic [W-1:0] count,
  input  logic         roll_evt,
  input  logic         ovf_clr,
  input  logic         trig_clr,
  output logic [W-1:0] cap,
  output logic         ovf_flag,
  output logic         trig_flag
);
  import cap_timer_pkg::*;

  localparam int NFLAG = 2;

  logic [W-1:0]     cap_q;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= count;
  end

  assign set_v = {cap_evt, roll_evt};
  assign clr_v = {trig_clr, ovf_clr};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[f] <= 1'b0;
      else     flag_q[f] <= flag_next(flag_q[f], set_v[f], clr_v[f]);
    end
  end

  assign cap       = cap_q;
  assign ovf_flag  = flag_q[0];
  assign trig_flag = flag_q[1];

endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 #(
  parameter int CNT_W  = 16,
  parameter int MC_LEN = 12,
  parameter int SMP_PH = 9,
  parameter int UPD_PH = 2,
  localparam int HW    = CNT_W / 2,
  localparam int PH_W  = $clog2(MC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          count_sel,
  input  logic          ext_en,
  input  logic          cnt_pin,
  input  logic          trig_pin,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [HW-1:0] wr_data,
  input  logic          ovf_clr,
  input  logic          trig_clr,
  output logic [HW-1:0] cnt_hi,
  output logic [HW-1:0] cnt_lo,
  output logic [HW-1:0] cap_hi,
  output logic [HW-1:0] cap_lo,
  output logic          ovf_flag,
  output logic          trig_flag,
  output logic          irq
);
  import cap_timer_pkg::*;

  localparam int LANE_CNT  = 0;
  localparam int LANE_TRIG = 1;

  count_mode_e       mode;
  logic [PH_W-1:0]   phase;
  logic              smp_stb;
  logic              upd_stb;
  logic [1:0]        pend;
  logic              inc_stb;
  logic              cap_evt;
  logic              roll_evt;
  logic              wr_any;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap;

  assign mode   = count_mode_e'(count_sel);
  assign wr_any = wr_hi | wr_lo;

  ct_phase_gen #(
    .MC_LEN(MC_LEN), .SMP_PH(SMP_PH), .UPD_PH(UPD_PH)
  ) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .smp_stb(smp_stb), .upd_stb(upd_stb)
  );

  ct_fall_sampler #(.N(2)) u_smp (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .upd_stb(upd_stb),
    .pin({trig_pin, cnt_pin}), .pend(pend)
  );

  assign inc_stb = run_en & upd_stb & ((mode == MODE_TIMER) | pend[LANE_CNT]);
  assign cap_evt = ext_en & upd_stb & pend[LANE_TRIG];

  ct_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .inc_stb(inc_stb), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .count(count), .roll_evt(roll_evt)
  );

  ct_event_regs #(.W(CNT_W)) u_evt (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .count(count), .roll_evt(roll_evt),
    .ovf_clr(ovf_clr), .trig_clr(trig_clr), .cap(cap),
    .ovf_flag(ovf_flag), .trig_flag(trig_flag)
  );

  assign cnt_hi = count[CNT_W-1:HW];
  assign cnt_lo = count[HW-1:0];
  assign cap_hi = cap[CNT_W-1:HW];
  assign cap_lo = cap[HW-1:0];
  assign irq    = ovf_flag | trig_flag;

endmodule

// File: rtl/cap_timer16_chk.sv
module cap_timer16_chk #(
  parameter int CNT_W  = 16,
  parameter int MC_LEN = 12,
  localparam int PH_W  = $clog2(MC_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             ext_en,
  input logic             wr_any,
  input logic [PH_W-1:0]  phase,
  input logic             smp_stb,
  input logic             upd_stb,
  input logic             inc_stb,
  input logic             roll_evt,
  input logic             cap_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap,
  input logic             ovf_flag,
  input logic             trig_flag
);

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    32'(phase) < MC_LEN);

  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_stb, upd_stb}));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && !wr_any) |=> count == $past(count) + CNT_W'(1));

  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_any) |=> $stable(count));

  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    roll_evt |=> (ovf_flag && count == '0));

  assert_capture_value_R7: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap == $past(count) && trig_flag));

  assert_no_capture_R8: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> $stable(cap));

endmodule

bind cap_timer16 cap_timer16_chk #(.CNT_W(CNT_W), .MC_LEN(MC_LEN)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .ext_en(ext_en), .wr_any(wr_any),
  .phase(phase), .smp_stb(smp_stb), .upd_stb(upd_stb), .inc_stb(inc_stb),
  .roll_evt(roll_evt), .cap_evt(cap_evt), .count(count), .cap(cap),
  .ovf_flag(ovf_flag), .trig_flag(trig_flag)
);

// File: tb/sim_cap_timer16.sv
module sim_cap_timer16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, run_en = 0, count_sel = 0, ext_en = 0;
  logic cnt_pin = 0, trig_pin = 0, wr_hi = 0, wr_lo = 0, ovf_clr = 0, trig_clr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_hi, cnt_lo, cap_hi, cap_lo;
  logic ovf_flag, trig_flag, irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  cap_timer16 u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .count_sel(count_sel), .ext_en(ext_en),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .trig_clr(trig_clr),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .ovf_flag(ovf_flag), .trig_flag(trig_flag), .irq(irq)
  );

  // Reference model, built from the requirements.
  int unsigned m_ph;
  logic m_sc, m_st, m_pc, m_pt, m_of, m_tf;
  logic [15:0] m_cnt, m_cap;

  function automatic logic [15:0] ref_count(input logic [15:0] c, input logic inc,
                                            input logic wh, input logic wl,
                                            input logic [7:0] d);
    logic [15:0] r;
    r = inc ? 16'(c + 16'd1) : c;
    if (wh) r = {d, r[7:0]};
    if (wl) r = {r[15:8], d};
    return r;
  endfunction

  function automatic logic ref_flag(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  always @(posedge clk) begin
    logic inc, wrap, capt;
    if (rst) begin
      m_ph <= 0; m_sc <= 0; m_st <= 0; m_pc <= 0; m_pt <= 0;
      m_cnt <= 0; m_cap <= 0; m_of <= 0; m_tf <= 0;
    end else begin
      m_ph <= (m_ph == 11) ? 0 : m_ph + 1;
      if (m_ph == 9) begin
        m_sc <= cnt_pin;  m_pc <= m_sc && !cnt_pin;
        m_st <= trig_pin; m_pt <= m_st && !trig_pin;
      end else if (m_ph == 2) begin
        m_pc <= 0; m_pt <= 0;
      end
      inc  = run_en && (m_ph == 2) && (!count_sel || m_pc);
      wrap = inc && (m_cnt == 16'hFFFF) && !wr_hi && !wr_lo;
      capt = ext_en && (m_ph == 2) && m_pt;
      m_cnt <= ref_count(m_cnt, inc, wr_hi, wr_lo, wr_data);
      if (capt) m_cap <= m_cnt;
      m_of <= ref_flag(m_of, wrap, ovf_clr);
      m_tf <= ref_flag(m_tf, capt, trig_clr);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    check({cnt_hi, cnt_lo} == m_cnt, "R2 count", {cnt_hi, cnt_lo}, m_cnt);
    check({cap_hi, cap_lo} == m_cap, "R7 capture", {cap_hi, cap_lo}, m_cap);
    check(ovf_flag == m_of, "R5 ovf_flag", ovf_flag, m_of);
    check(trig_flag == m_tf, "R7 trig_flag", trig_flag, m_tf);
    check(irq == (m_of | m_tf), "R11 irq", irq, m_of | m_tf);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [15:0] held, snap;
    int hold_c, hold_t;
    void'($urandom(32'd2024));
    step(4);
    check({cnt_hi, cnt_lo, cap_hi, cap_lo} == 0 && !ovf_flag && !trig_flag,
          "R1 reset", {cnt_hi, cnt_lo}, 0);
    rst = 0;

    // R5: preset FFFF in timer mode, one machine cycle wraps it.
    run_en = 1; count_sel = 0; ext_en = 0;
    wr_hi = 1; wr_lo = 1; wr_data = 8'hFF; step(1);
    wr_hi = 0; wr_lo = 0; step(12);
    check({cnt_hi, cnt_lo} == 16'h0000, "R5 wrap", {cnt_hi, cnt_lo}, 0);
    check(ovf_flag && irq, "R5 R11 flag", ovf_flag, 1);
    step(20);
    check(ovf_flag, "R6 flag persists", ovf_flag, 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    check(!ovf_flag, "R6 flag cleared", ovf_flag, 0);

    // R10: write lands exactly on an update edge.
    while (m_ph != 2) step(1);
    wr_hi = 1; wr_lo = 1; wr_data = 8'hFF; step(1);
    wr_hi = 0; wr_lo = 0;
    check({cnt_hi, cnt_lo} == 16'hFFFF && !ovf_flag, "R10 write priority",
          {cnt_hi, cnt_lo}, 16'hFFFF);
    step(12); ovf_clr = 1; step(1); ovf_clr = 0;

    // R9 + R7: stopped counter still captures.
    run_en = 0; ext_en = 1; trig_pin = 1; step(30);
    held = {cnt_hi, cnt_lo};
    trig_pin = 0; step(30);
    check({cap_hi, cap_lo} == held && trig_flag, "R7 capture", {cap_hi, cap_lo}, held);
    check({cnt_hi, cnt_lo} == held, "R9 hold", {cnt_hi, cnt_lo}, held);
    trig_clr = 1; step(1); trig_clr = 0;
    check(!trig_flag, "R6 trig cleared", trig_flag, 0);

    // R8: capture disabled.
    ext_en = 0; snap = {cap_hi, cap_lo};
    trig_pin = 1; step(30); trig_pin = 0; step(30);
    check({cap_hi, cap_lo} == snap && !trig_flag, "R8 no capture", {cap_hi, cap_lo}, snap);

    // R3: five full-length pulses give five counts.
    run_en = 1; count_sel = 1;
    wr_hi = 1; wr_lo = 1; wr_data = 8'h00; step(1); wr_hi = 0; wr_lo = 0;
    for (int k = 0; k < 5; k++) begin
      cnt_pin = 1; step(24); cnt_pin = 0; step(24);
    end
    step(24);
    check({cnt_hi, cnt_lo} == 16'd5, "R3 event count", {cnt_hi, cnt_lo}, 5);

    // R4: latency from sample edge to increment.
    cnt_pin = 1; step(24);
    while (m_ph != 9) step(1);
    cnt_pin = 0; held = {cnt_hi, cnt_lo}; step(1);
    step(4);
    check({cnt_hi, cnt_lo} == held, "R4 not yet", {cnt_hi, cnt_lo}, held);
    step(1);
    check({cnt_hi, cnt_lo} == 16'(held + 1), "R4 applied", {cnt_hi, cnt_lo}, held + 1);

    // Random mix, checked cycle by cycle by the model.
    hold_c = 10; hold_t = 10;
    for (int i = 0; i < 30000; i++) begin
      wr_hi = 0; wr_lo = 0; ovf_clr = 0; trig_clr = 0;
      if (--hold_c <= 0) begin cnt_pin = ~cnt_pin; hold_c = 4 + int'($urandom % 40); end
      if (--hold_t <= 0) begin trig_pin = ~trig_pin; hold_t = 4 + int'($urandom % 40); end
      if ($urandom % 700 == 0) begin
        run_en = 1'($urandom); count_sel = 1'($urandom); ext_en = 1'($urandom);
      end
      if ($urandom % 250 == 0) begin
        wr_hi = 1'($urandom); wr_lo = 1'($urandom);
        wr_data = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      end
      if ($urandom % 60 == 0) ovf_clr = 1;
      if ($urandom % 60 == 0) trig_clr = 1;
      step(1);
    end
    wr_hi = 0; wr_lo = 0; ovf_clr = 0; trig_clr = 0;
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule